// File: doc/BRIEF.md
# Sixteen-Bit Single-Cycle Processor Core

This block is a compact processor core that completes one instruction on every clock edge. It reads a 16-bit instruction from a small internal instruction store using a byte-addressed program counter. It decodes the instruction at once and either commits an arithmetic or logic result to one of eight 16-bit registers or redirects the program counter. Three instructions redirect it: a test for zero, a test for negative and an unconditional jump. A halt instruction stops the core, which then stays idle until the next reset.

Instruction layout:

| Bits | Field |
|------|-------|
| 15:14 | unused |
| 13:10 | opcode |
| 9 | write-back enable |
| 8:6 | first source register |
| 5:3 | second source register |
| 2:0 | destination register |

Control-transfer instructions use bits 5:0 as a byte-address target.

The surrounding system fills the instruction store through a word-wide write port while the core is held in reset. It uses a debug port to seed registers before a run and to read them afterwards. The single status output tells the caller when the program has stopped.

Top module: `mini16_core`

## Requirements
- R1: Opcodes 0x0 to 0x8 compute the following, modulo 2^16, into the destination register:
  - 0x0: a+b
  - 0x1: a−b
  - 0x2: a<<1
  - 0x3: a>>1
  - 0x4: ~a
  - 0x5: a^b
  - 0x6: a|b
  - 0x7: a&b
  - 0x8: a+1

  Here a is the register named by bits 8:6 and b is the register named by bits 5:3.
- R2: A register is written by an instruction only when bit 9 is 1 and the opcode is 0x0 to 0x8; with bit 9 at 0 no register changes.
- R3: When no transfer is taken the 6-bit program counter advances by 2 and wraps from 62 to 0.
- R4: Opcode 0x9 loads the program counter with bits 5:0 when the register named by bits 8:6 equals zero, else advances.
- R5: Opcode 0xA loads the program counter with bits 5:0 when bit 15 of the register named by bits 8:6 is 1; a zero register does not branch.
- R6: Opcode 0xE always loads bits 5:0 into the program counter; the word fetched is selected by program counter bits 5:1, so an odd target reaches the even word below it.
- R7: Opcode 0xF raises the halted output on the next edge; halted then stays high and no register changes until reset.
- R8: Opcodes 0xB, 0xC and 0xD only advance the program counter, even with bit 9 set.
- R9: A synchronous reset clears the program counter and halted and leaves register contents unchanged.
- R10: A debug write sets the addressed register on the clock edge and wins over a core write to the same register in that cycle; the debug read is combinational.
- R11: An instruction-store write puts the data word at the given word address (byte address divided by two) on the clock edge.
- R12: Opcode 0x3 shifts in a zero at bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| imem_we_i | input | 1 | Instruction-store write strobe |
| imem_waddr_i | input | 5 | Instruction-store word address |
| imem_wdata_i | input | 16 | Instruction word to store |
| dbg_we_i | input | 1 | Register debug write strobe |
| dbg_addr_i | input | 3 | Register selected for debug read and write |
| dbg_wdata_i | input | 16 | Debug write data |
| dbg_rdata_o | output | 16 | Current value of the selected register |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The program-counter properties assume that the instruction store holds known words once reset is released. The stimulus always fills all 32 words before releasing reset, with halts in every unused slot. The write-landing property counts only writes made outside reset, so it assumes debug writes during a run are rare. The stimulus issues exactly one such write, deliberately colliding with a core write-back to exercise the priority rule. Every other debug write happens while reset is held, and the stimulus never changes the instruction store while the core runs.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
    parameter int XLEN       = 16;
    parameter int NREG       = 8;
    parameter int IMEM_WORDS = 32;

    localparam int REG_AW  = $clog2(NREG);
    localparam int IMEM_AW = $clog2(IMEM_WORDS);
    localparam int PC_W    = IMEM_AW + 1;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_SHL  = 4'h2,
        OP_SHR  = 4'h3,
        OP_NOT  = 4'h4,
        OP_XOR  = 4'h5,
        OP_OR   = 4'h6,
        OP_AND  = 4'h7,
        OP_INC  = 4'h8,
        OP_BZ   = 4'h9,
        OP_BNEG = 4'hA,
        OP_RSVB = 4'hB,
        OP_RSVC = 4'hC,
        OP_RSVD = 4'hD,
        OP_JMP  = 4'hE,
        OP_STOP = 4'hF
    } op_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            halted;
    } core_state_t;
endpackage

// File: rtl/mini16_alu.sv
module mini16_alu
    import mini16_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  op_e           op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_SHL:  res_o = {a_i[DW-2:0], 1'b0};
            OP_SHR:  res_o = {1'b0, a_i[DW-1:1]};
            OP_NOT:  res_o = ~a_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_INC:  res_o = a_i + {{(DW-1){1'b0}}, 1'b1};
            default: res_o = '0;
        endcase
    end

    // Right shift must never bring in a one at the top (R12).
    always_comb begin
        if (op_i == OP_SHR) begin
            p_shr_zero_fill_r12: assert (res_o[DW-1] == 1'b0);
        end
    end
endmodule

// File: rtl/mini16_imem.sv
module mini16_imem
    import mini16_pkg::*;
#(
    parameter int WORDS = IMEM_WORDS,
    parameter int DW    = XLEN,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile
    import mini16_pkg::*;
#(
    parameter int NR    = NREG,
    parameter int DW    = XLEN,
    localparam int AW   = $clog2(NR)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] ra1_i,
    output logic [DW-1:0] rd1_o,
    input  logic [AW-1:0] ra2_i,
    output logic [DW-1:0] rd2_o,
    input  logic [AW-1:0] ra3_i,
    output logic [DW-1:0] rd3_o
);
    logic [DW-1:0] regs_d [NR];
    logic [DW-1:0] regs_q [NR];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    // Contents are deliberately not reset so that preloads survive (R9).
    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign rd1_o = regs_q[ra1_i];
    assign rd2_o = regs_q[ra2_i];
    assign rd3_o = regs_q[ra3_i];

    // A granted write is visible on the following cycle (R2, R10).
    p_write_lands_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mini16_core.sv
module mini16_core
    import mini16_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               imem_we_i,
    input  logic [IMEM_AW-1:0] imem_waddr_i,
    input  logic [XLEN-1:0]    imem_wdata_i,
    input  logic               dbg_we_i,
    input  logic [REG_AW-1:0]  dbg_addr_i,
    input  logic [XLEN-1:0]    dbg_wdata_i,
    output logic [XLEN-1:0]    dbg_rdata_o,
    output logic               halted_o
);
    core_state_t st_d, st_q;

    logic [XLEN-1:0]   instr;
    logic [XLEN-1:0]   rs1_val, rs2_val, alu_res, rf_wdata;
    op_e               op;
    logic              wb_en;
    logic [REG_AW-1:0] src1, src2, dst, rf_waddr;
    logic [PC_W-1:0]   target, pc_seq;
    logic              core_we, rf_we;
    logic              unused_spare;

    assign op           = op_e'(instr[13:10]);
    assign wb_en        = instr[9];
    assign src1         = instr[8:6];
    assign src2         = instr[5:3];
    assign dst          = instr[2:0];
    assign target       = instr[PC_W-1:0];
    assign unused_spare = ^instr[15:14];
    assign pc_seq       = st_q.pc + PC_W'(2);

    mini16_imem u_imem (
        .clk_i   (clk_i),
        .we_i    (imem_we_i),
        .waddr_i (imem_waddr_i),
        .wdata_i (imem_wdata_i),
        .raddr_i (st_q.pc[PC_W-1:1]),
        .rdata_o (instr)
    );

    mini16_alu u_alu (
        .op_i  (op),
        .a_i   (rs1_val),
        .b_i   (rs2_val),
        .res_o (alu_res)
    );

    // Debug access takes the write port ahead of the core (R10).
    assign rf_we    = dbg_we_i | core_we;
    assign rf_waddr = dbg_we_i ? dbg_addr_i  : dst;
    assign rf_wdata = dbg_we_i ? dbg_wdata_i : alu_res;

    mini16_regfile u_rf (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .ra1_i   (src1),
        .rd1_o   (rs1_val),
        .ra2_i   (src2),
        .rd2_o   (rs2_val),
        .ra3_i   (dbg_addr_i),
        .rd3_o   (dbg_rdata_o)
    );

    always_comb begin
        st_d    = st_q;
        core_we = 1'b0;
        if (rst_i) begin
            st_d = '0;
        end else if (!st_q.halted) begin
            case (op)
                OP_ADD, OP_SUB, OP_SHL, OP_SHR, OP_NOT,
                OP_XOR, OP_OR, OP_AND, OP_INC: begin
                    core_we = wb_en;
                    st_d.pc = pc_seq;
                end
                OP_BZ:   st_d.pc = (rs1_val == '0) ? target : pc_seq;
                OP_BNEG: st_d.pc = rs1_val[XLEN-1] ? target : pc_seq;
                OP_JMP:  st_d.pc = target;
                OP_STOP: st_d.halted = 1'b1;
                default: st_d.pc = pc_seq;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign halted_o = st_q.halted;

    p_halt_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.halted |=> st_q.halted);

    p_halt_freezes_pc_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.halted |=> $stable(st_q.pc));

    p_seq_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.halted && instr[13:10] < 4'h9) |=> st_q.pc == $past(st_q.pc) + PC_W'(2));

    p_jump_taken_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.halted && op == OP_JMP) |=> st_q.pc == $past(instr[PC_W-1:0]));

    p_zero_branch_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.halted && op == OP_BZ && rs1_val == '0) |=> st_q.pc == $past(instr[PC_W-1:0]));
endmodule

// File: tb/mini16_core_tb_top.sv
`timescale 1ns/1ps
module mini16_core_tb_top;
    import mini16_pkg::*;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [4:0]  imem_waddr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dbg_we = 1'b0;
    logic [2:0]  dbg_addr = '0;
    logic [15:0] dbg_wdata = '0;
    logic [15:0] dbg_rdata;
    logic        halted;

    always #HALF clk = ~clk;

    mini16_core dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .imem_we_i    (imem_we),
        .imem_waddr_i (imem_waddr),
        .imem_wdata_i (imem_wdata),
        .dbg_we_i     (dbg_we),
        .dbg_addr_i   (dbg_addr),
        .dbg_wdata_i  (dbg_wdata),
        .dbg_rdata_o  (dbg_rdata),
        .halted_o     (halted)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_reg [8];
    logic [15:0] m_mem [32];
    int          m_pc = 0;
    bit          m_halt = 0;
    logic [15:0] mi, ma, mb, mr;
    int          mop, mnext;

    always @(posedge clk) begin
        if (rst) begin
            m_pc   = 0;
            m_halt = 0;
        end else if (!m_halt) begin
            mi    = m_mem[(m_pc / 2) % 32];
            mop   = int'(mi[13:10]);
            ma    = m_reg[mi[8:6]];
            mb    = m_reg[mi[5:3]];
            mnext = (m_pc + 2) % 64;
            case (mop)
                0: mr = ma + mb;
                1: mr = ma - mb;
                2: mr = ma << 1;
                3: mr = ma >> 1;
                4: mr = ~ma;
                5: mr = ma ^ mb;
                6: mr = ma | mb;
                7: mr = ma & mb;
                8: mr = ma + 16'd1;
                default: mr = 16'd0;
            endcase
            if (mop <= 8 && mi[9]) m_reg[mi[2:0]] = mr;
            if (mop == 9 && ma == 16'd0) mnext = int'(mi[5:0]);
            if (mop == 10 && ma[15]) mnext = int'(mi[5:0]);
            if (mop == 14) mnext = int'(mi[5:0]);
            if (mop == 15) begin
                m_halt = 1;
                mnext  = m_pc;
            end
            m_pc = mnext;
        end
        if (dbg_we) m_reg[dbg_addr] = dbg_wdata;
        if (imem_we) m_mem[imem_waddr] = imem_wdata;
    end

    // ---------------- helpers ----------------
    logic [15:0] prog [32];
    logic [15:0] pre  [8];

    function automatic logic [15:0] enc(input int op, input int w, input int s1,
                                        input int s2, input int d);
        return {2'b00, 4'(op), 1'(w), 3'(s1), 3'(s2), 3'(d)};
    endfunction

    function automatic logic [15:0] enct(input int op, input int s1, input int tgt);
        return {2'b00, 4'(op), 1'b0, 3'(s1), 6'(tgt)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 32; i++) prog[i] = 16'h3C00;
        for (int i = 0; i < 8; i++) pre[i] = 16'h0000;
    endtask

    // R11: each word goes to its own word address while reset is held.
    task automatic load_and_start();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 32; i++) begin
            imem_we = 1'b1; imem_waddr = 5'(i); imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        for (int i = 0; i < 8; i++) begin
            dbg_we = 1'b1; dbg_addr = 3'(i); dbg_wdata = pre[i];
            @(negedge clk);
        end
        dbg_we = 1'b0;
        rst    = 1'b0;
    endtask

    // Compare the design against the model once per clock.
    task automatic run_cycle();
        @(negedge clk);
        dbg_addr = 3'(cyc % 8);
        #1;
        check(halted == m_halt, "R7 per-cycle halted", {15'd0, halted}, {15'd0, m_halt});
        check(dbg_rdata == m_reg[dbg_addr], "R1 per-cycle register", dbg_rdata, m_reg[dbg_addr]);
        cyc++;
    endtask

    task automatic run_to_halt(input int limit);
        int k;
        k = 0;
        while (!m_halt && k < limit) begin
            run_cycle();
            k++;
        end
        if (k >= limit) check(1'b0, "R7 program never halted", 16'd0, 16'd1);
        for (int i = 0; i < 3; i++) run_cycle();
    endtask

    task automatic expect_reg(input int idx, input logic [15:0] exp, input string tag);
        @(negedge clk);
        dbg_addr = 3'(idx);
        #1;
        check(dbg_rdata == exp, tag, dbg_rdata, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(64'd20 * 64'd150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        @(negedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R9 reset state halted", {15'd0, halted}, 16'd0);

        // Program A: every ALU operation, write-enable off, reserved opcodes.
        clear_prog();
        pre[1] = 16'h8001; pre[2] = 16'h1234;
        prog[0]  = enc(0, 1, 1, 2, 3);
        prog[1]  = enc(1, 1, 2, 1, 4);
        prog[2]  = enc(2, 1, 1, 0, 5);
        prog[3]  = enc(3, 1, 1, 0, 6);
        prog[4]  = enc(4, 1, 2, 0, 7);
        prog[5]  = enc(5, 0, 1, 7, 3);
        prog[6]  = enc(6, 1, 1, 2, 0);
        prog[7]  = enc(7, 1, 1, 2, 4);
        prog[8]  = enc(8, 1, 5, 0, 5);
        prog[9]  = enc(11, 1, 2, 0, 1);
        prog[10] = enc(12, 1, 2, 0, 1);
        prog[11] = enc(13, 1, 2, 0, 2);
        load_and_start();
        run_to_halt(100);
        expect_reg(3, 16'h9235, "R1 R11 add result, xor not written");
        expect_reg(4, 16'h0000, "R1 and result");
        expect_reg(5, 16'h0003, "R1 shift-left then increment");
        expect_reg(6, 16'h4000, "R12 logical right shift");
        expect_reg(7, 16'hEDCB, "R1 bitwise invert");
        expect_reg(0, 16'h9235, "R1 or result");
        expect_reg(3, 16'h9235, "R2 write-enable clear leaves dst");
        expect_reg(1, 16'h8001, "R8 reserved opcode no write");
        expect_reg(2, 16'h1234, "R8 reserved opcode 0xD no write");
        check(halted == 1'b1, "R7 halted held", {15'd0, halted}, 16'd1);

        // Reset while halted: halted clears, registers stay.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(halted == 1'b0, "R9 reset clears halted", {15'd0, halted}, 16'd0);
        dbg_addr = 3'd7;
        #1;
        check(dbg_rdata == 16'hEDCB, "R9 reset keeps registers", dbg_rdata, 16'hEDCB);

        // Program B: counted loop, negative branch to odd target, not-taken cases.
        clear_prog();
        pre[1] = 16'd5; pre[5] = 16'h7FFF; pre[6] = 16'h8000; pre[7] = 16'd1;
        prog[0]  = enct(9, 1, 10);
        prog[1]  = enc(8, 1, 2, 0, 2);
        prog[2]  = enc(1, 1, 1, 7, 1);
        prog[3]  = enct(14, 0, 0);
        prog[4]  = enc(8, 1, 0, 0, 0);
        prog[5]  = enct(10, 6, 15);
        prog[6]  = enc(8, 1, 4, 0, 4);
        prog[7]  = enct(10, 1, 20);
        prog[8]  = enct(9, 5, 20);
        prog[9]  = enc(8, 1, 3, 0, 3);
        prog[10] = 16'h3C00;
        load_and_start();
        run_to_halt(200);
        expect_reg(2, 16'd5, "R4 zero branch exits loop after five passes");
        expect_reg(1, 16'd0, "R4 loop counter reaches zero");
        expect_reg(0, 16'd0, "R6 jump skips following word");
        expect_reg(4, 16'd0, "R5 negative branch taken");
        expect_reg(3, 16'd1, "R6 odd target selects even word; R5 zero not taken");

        // Program C: counter wrap from 62 to 0.
        clear_prog();
        prog[0]  = enct(9, 2, 62);
        prog[31] = enc(8, 1, 2, 0, 2);
        load_and_start();
        run_to_halt(100);
        expect_reg(2, 16'd1, "R3 wrap from 62 to 0");

        // Program D: debug write collides with a core write-back.
        clear_prog();
        pre[1] = 16'h0010;
        prog[0] = enc(8, 1, 1, 0, 1);
        prog[1] = enct(14, 0, 0);
        load_and_start();
        dbg_we = 1'b1; dbg_addr = 3'd1; dbg_wdata = 16'h0ABC;
        @(negedge clk);
        dbg_we = 1'b0;
        #1;
        check(dbg_rdata == 16'h0ABC, "R10 debug write wins", dbg_rdata, 16'h0ABC);
        for (int i = 0; i < 4; i++) run_cycle();
        expect_reg(1, 16'h0ABE, "R10 core continues from debug value");
        check(halted == 1'b0, "R7 no halt without halt opcode", {15'd0, halted}, 16'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule